// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a 16-bit down-counting watchdog. Software sets a reload value and a control word, then has to keep writing a fixed key to a refresh register before the count runs out. Counting is driven by a slow tick enable that shares the system clock, divided by a prescaler that can be selected. When the count expires, or when the key is wrong, the block raises a sticky interrupt flag or asserts a sticky reset request. The control word chooses which of the two happens.

An optional window mode turns a correctly keyed refresh into a fault when it arrives while the count is still above a programmed minimum. A power-down input can pause counting if the control word allows it. Once the timer has been enabled, its control word is locked until reset. Each register write shows a busy flag in status until two slow ticks have passed, which stands in for synchronisation into the slow timer domain.

Top module: `wdt_window_top`

## Requirements
- R1: After reset the count and reload registers read 0xFFFF, the minimum register reads 0, control and status read 0, and both `irq` and `rst_req` are low.
- R2: The register addresses are reload 0, live count 1 (read only), control 2, refresh 3, status 4 and minimum 5. The live count can be read at any time through `rd_data`.
- R3: The control bits are: bit0 enable, bit1 action (1 = interrupt, 0 = reset), bits3:2 prescaler code, bit4 interrupt pin enable, bit5 power-down pause, bit6 extra divide by 2, bit7 window enable. A control write with bit0 = 1 copies the reload value into the count and sets the lock flag (status bit1). While lock is set, control writes are ignored.
- R4: While the timer is enabled, the count drops by one on every prescaled tick. Codes 0 to 3 divide the tick by 1, 16, 256 and 4096, and bit6 doubles the divisor.
- R5: A refresh write of 0xCCCC while enabled reloads the count. Any other value written there is a fault.
- R6: A prescaled tick that arrives while the count is 0 is a timeout fault.
- R7: In interrupt action a fault sets status bit0 and reloads the count. `irq` equals status bit0 AND control bit4. Writing 1 to status bit0 clears the flag.
- R8: In reset action a fault sets `rst_req`. It stays high and counting stops until reset.
- R9: With window enable set, a refresh of 0xCCCC while the count is above the minimum register is a fault. At or below the minimum it is accepted.
- R10: With control bit5 set and `pd_in` high, the count holds.
- R11: Status bits 2, 3, 4 and 5 (control, reload, refresh, minimum) are set by the matching write and fall after the second following slow tick.
- R12: Refresh writes are ignored while the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow tick enable, one clock wide |
| pd_in | input | 1 | Power-down indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | System reset request |

## Verification
Writes, refresh results, faults and count steps all appear in the registers at the clock edge that samples the write or the tick. Because reads are combinational, each result can be seen half a cycle after that edge. The bench drives every input on the falling edge and reads back one falling edge after the strobe, so it always reads the value from the edge that took the stimulus. Busy flags are checked after the first tick, when they must still be high, and after the second tick, when they must be low. Prescaled results are checked one tick before and exactly at the divisor boundary.

// File: rtl/wdt_window_pkg.sv
package wdt_window_pkg;
  localparam int CW = 16;
  localparam int AW = 3;
  localparam logic [CW-1:0] REFRESH_KEY = 16'hCCCC;
  localparam logic [AW-1:0] ADR_RELOAD  = 3'd0;
  localparam logic [AW-1:0] ADR_COUNT   = 3'd1;
  localparam logic [AW-1:0] ADR_CTRL    = 3'd2;
  localparam logic [AW-1:0] ADR_REFRESH = 3'd3;
  localparam logic [AW-1:0] ADR_STATUS  = 3'd4;
  localparam logic [AW-1:0] ADR_MINIMUM = 3'd5;

  typedef struct packed {
    logic       win;
    logic       div2;
    logic       pdpause;
    logic       ie;
    logic [1:0] pre;
    logic       act_irq;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/wdt_window_presc.sv
module wdt_window_presc #(
  parameter int STEP  = 4,
  parameter int CODES = 4,
  localparam int PW   = STEP * (CODES - 1) + 2,
  localparam int SHW  = $clog2(PW + 1),
  localparam int SW   = $clog2(CODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          clear,
  input  logic [SW-1:0] pre,
  input  logic          div2,
  output logic          adv
);
  logic [PW-1:0]  pcnt_q, pcnt_d, term;
  logic [SHW-1:0] shamt;

  always_comb begin
    shamt = SHW'(pre) * SHW'(STEP) + SHW'(div2);
    term  = (PW'(1) << shamt) - PW'(1);
    adv   = run && tick && (pcnt_q == term);
    if (clear)            pcnt_d = '0;
    else if (adv)         pcnt_d = '0;
    else if (run && tick) pcnt_d = pcnt_q + PW'(1);
    else                  pcnt_d = pcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R4
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pcnt_q == '0));
endmodule

// File: rtl/wdt_window_busy.sv
module wdt_window_busy #(
  parameter int N    = 4,
  parameter int HOLD = 2,
  localparam int HW  = $clog2(HOLD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] set,
  output logic [N-1:0] busy
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic [HW-1:0] cnt_q, cnt_d;
    always_comb begin
      if (set[g])                       cnt_d = HW'(HOLD);
      else if (tick && cnt_q != '0)     cnt_d = cnt_q - HW'(1);
      else                              cnt_d = cnt_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
    assign busy[g] = (cnt_q != '0);

    // R11
    busy_hold_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> busy[g]);
  end
endmodule

// File: rtl/wdt_window_count.sv
module wdt_window_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [CW-1:0] reload_val,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          at_zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (reload)                   cnt_d = reload_val;
    else if (adv && cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_zero = (cnt_q == '0);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !adv) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_window_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pd_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          irq,
  output logic          rst_req
);
  localparam int NBUSY = 4;

  ctl_t          ctl_q, ctl_d;
  logic [CW-1:0] reload_q, reload_d, minimum_q, minimum_d;
  logic          lock_q, lock_d, irqf_q, irqf_d, rreq_q, rreq_d;
  logic [CW-1:0] cnt;
  logic          at_zero, adv, run;
  logic          ctl_wr, reload_wr, min_wr, ref_wr, stat_wr, refresh;
  logic          key_ok, early, bad_key, timeout, fault, good_ref, start, reload;
  logic [NBUSY-1:0] busy, busy_set;

  always_comb begin
    ctl_wr    = wr_en && wr_addr == ADR_CTRL && !lock_q;
    reload_wr = wr_en && wr_addr == ADR_RELOAD;
    min_wr    = wr_en && wr_addr == ADR_MINIMUM;
    ref_wr    = wr_en && wr_addr == ADR_REFRESH;
    stat_wr   = wr_en && wr_addr == ADR_STATUS;
    refresh   = ref_wr && ctl_q.en && !rreq_q;
    key_ok    = (wr_data == REFRESH_KEY);
    early     = refresh && key_ok && ctl_q.win && (cnt > minimum_q);
    bad_key   = refresh && !key_ok;
    run       = ctl_q.en && !(ctl_q.pdpause && pd_in) && !rreq_q;
    timeout   = adv && at_zero;
    fault     = timeout || early || bad_key;
    good_ref  = refresh && key_ok && !early;
    start     = ctl_wr && wr_data[0];
    reload    = start || good_ref || (fault && ctl_q.act_irq);
    busy_set  = {min_wr, ref_wr, reload_wr, ctl_wr};
  end

  always_comb begin
    ctl_d     = ctl_wr ? ctl_t'(wr_data[7:0]) : ctl_q;
    reload_d  = reload_wr ? wr_data : reload_q;
    minimum_d = min_wr ? wr_data : minimum_q;
    lock_d    = lock_q || start;
    rreq_d    = rreq_q || (fault && !ctl_q.act_irq);
    if (fault && ctl_q.act_irq)    irqf_d = 1'b1;
    else if (stat_wr && wr_data[0]) irqf_d = 1'b0;
    else                           irqf_d = irqf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      reload_q  <= '1;
      minimum_q <= '0;
      lock_q    <= 1'b0;
      irqf_q    <= 1'b0;
      rreq_q    <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      reload_q  <= reload_d;
      minimum_q <= minimum_d;
      lock_q    <= lock_d;
      irqf_q    <= irqf_d;
      rreq_q    <= rreq_d;
    end
  end

  wdt_window_presc #(.STEP(4), .CODES(4)) presc_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clear(reload),
    .pre(ctl_q.pre), .div2(ctl_q.div2), .adv(adv));

  wdt_window_count #(.CW(CW)) count_i (
    .clk(clk), .rst_n(rst_n), .reload(reload), .reload_val(reload_q),
    .adv(adv), .cnt(cnt), .at_zero(at_zero));

  wdt_window_busy #(.N(NBUSY), .HOLD(2)) busy_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set(busy_set), .busy(busy));

  always_comb begin
    case (rd_addr)
      ADR_RELOAD:  rd_data = reload_q;
      ADR_COUNT:   rd_data = cnt;
      ADR_CTRL:    rd_data = {8'h00, ctl_q};
      ADR_STATUS:  rd_data = {10'h000, busy, lock_q, irqf_q};
      ADR_MINIMUM: rd_data = minimum_q;
      default:     rd_data = '0;
    endcase
  end

  assign irq     = irqf_q && ctl_q.ie;
  assign rst_req = rreq_q;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R3
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && wr_addr == ADR_CTRL) |=> $stable(ctl_q));
  // R8
  rreq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> (rreq_q && $stable(cnt)));
  // R10
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && ctl_q.pdpause && pd_in && !wr_en) |=> $stable(cnt));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !(wr_en && wr_addr == ADR_CTRL)) |=> $stable(cnt));
endmodule

// File: tb/wdt_window_top_tb_top.sv
module wdt_window_top_tb_top;
  logic        clk, rst_n, tick, pd_in, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        irq, rst_req;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  wdt_window_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pd_in(pd_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .rst_req(rst_req));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0; pd_in = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] exp_count(input int load, input int steps);
    return (steps >= load) ? 16'd0 : 16'(load - steps);
  endfunction

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    rd_chk("R1 count", 3'd1, 16'hFFFF);
    rd_chk("R1 reload", 3'd0, 16'hFFFF);
    rd_chk("R1 minimum", 3'd5, 16'h0000);
    rd_chk("R1 control", 3'd2, 16'h0000);
    rd_chk("R1 status", 3'd4, 16'h0000);
    chk("R1 irq/rst_req", {14'd0, irq, rst_req}, 16'd0);

    // R2 R3 R11 start, lock and busy
    wr(3'd0, 16'd10);
    rd_chk("R11 reload busy", 3'd4, 16'h0008);
    rd_chk("R2 reload readback", 3'd0, 16'd10);
    wr(3'd2, 16'h0013);
    rd_chk("R3 count loaded", 3'd1, 16'd10);
    rd_chk("R3 lock + busy", 3'd4, 16'h000E);
    ticks(1, 0);
    rd_chk("R11 busy after one tick", 3'd4, 16'h000E);
    ticks(1, 0);
    rd_chk("R11 busy cleared", 3'd4, 16'h0002);
    rd_chk("R4 decrement", 3'd1, 16'd8);
    wr(3'd2, 16'h0000);
    rd_chk("R3 control locked", 3'd2, 16'h0013);
    rd_chk("R3 still counting", 3'd1, 16'd8);
    // R5 good refresh
    wr(3'd3, 16'hCCCC);
    rd_chk("R5 refresh reload", 3'd1, 16'd10);
    // R6 R7 timeout in interrupt action
    ticks(10, 1);
    rd_chk("R6 reached zero", 3'd1, 16'd0);
    chk("R6 no fault at zero", {15'd0, irq}, 16'd0);
    ticks(1, 0);
    chk("R7 irq on timeout", {15'd0, irq}, 16'd1);
    rd_chk("R7 reload after fault", 3'd1, 16'd10);
    wr(3'd4, 16'h0001);
    chk("R7 flag cleared", {15'd0, irq}, 16'd0);
    // R5 bad key
    wr(3'd3, 16'h1234);
    chk("R5 bad key fault", {15'd0, irq}, 16'd1);
    chk("R8 no reset in irq action", {15'd0, rst_req}, 16'd0);

    // R9 R10 window and power-down pause
    do_reset();
    wr(3'd0, 16'd5);
    wr(3'd5, 16'd3);
    wr(3'd2, 16'h00B3);
    wr(3'd3, 16'hCCCC);
    chk("R9 early refresh fault", {15'd0, irq}, 16'd1);
    wr(3'd4, 16'h0001);
    ticks(2, 0);
    rd_chk("R9 count at minimum", 3'd1, 16'd3);
    wr(3'd3, 16'hCCCC);
    chk("R9 in-window accepted", {15'd0, irq}, 16'd0);
    rd_chk("R9 reloaded", 3'd1, 16'd5);
    pd_in = 1'b1;
    ticks(3, 0);
    rd_chk("R10 paused", 3'd1, 16'd5);
    pd_in = 1'b0;
    ticks(1, 0);
    rd_chk("R10 resumed", 3'd1, 16'd4);

    // R8 reset action
    do_reset();
    wr(3'd0, 16'd2);
    wr(3'd2, 16'h0001);
    ticks(2, 0);
    chk("R8 not yet", {15'd0, rst_req}, 16'd0);
    ticks(1, 0);
    chk("R8 reset request", {15'd0, rst_req}, 16'd1);
    chk("R8 no irq", {15'd0, irq}, 16'd0);
    ticks(2, 0);
    chk("R8 sticky", {15'd0, rst_req}, 16'd1);
    rd_chk("R8 count frozen", 3'd1, 16'd0);

    // R12 refresh ignored while disabled
    do_reset();
    wr(3'd3, 16'h0000);
    chk("R12 no fault disabled", {14'd0, irq, rst_req}, 16'd0);
    rd_chk("R12 count untouched", 3'd1, 16'hFFFF);

    // R4 prescaler codes
    do_reset();
    wr(3'd0, 16'd100);
    wr(3'd2, 16'h0005);
    ticks(31, 0);
    rd_chk("R4 div16 before", 3'd1, 16'd99);
    ticks(1, 0);
    rd_chk("R4 div16 boundary", 3'd1, 16'd98);
    do_reset();
    wr(3'd0, 16'd100);
    wr(3'd2, 16'h0045);
    ticks(63, 0);
    rd_chk("R4 div32 before", 3'd1, 16'd99);
    ticks(1, 0);
    rd_chk("R4 div32 boundary", 3'd1, 16'd98);
    do_reset();
    wr(3'd0, 16'd5);
    wr(3'd2, 16'h000D);
    ticks(4095, 0);
    rd_chk("R4 div4096 before", 3'd1, 16'd5);
    ticks(1, 0);
    rd_chk("R4 div4096 boundary", 3'd1, 16'd4);

    // R4 R6 R7 random loads and tick spacing
    for (int it = 0; it < 8; it++) begin
      int load = $urandom_range(40, 3);
      int k    = $urandom_range(load, 0);
      int gap  = $urandom_range(2, 0);
      do_reset();
      wr(3'd0, 16'(load));
      wr(3'd2, 16'h0013);
      ticks(k, gap);
      rd_chk("R4 random count", 3'd1, exp_count(load, k));
      ticks(load - k + 1, gap);
      chk("R6 random timeout", {15'd0, irq}, 16'd1);
      rd_chk("R7 random reload", 3'd1, 16'(load));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule